// File: doc/BRIEF.md
# Interleaved Multi-Group Payload Permuter

The block scrambles, or restores, the order of the codewords in a 1920-bit packet payload. The payload is taken as two classes of codewords. Twenty-four 32-bit codewords come first and seventy-two 16-bit codewords follow. Each class is dealt round-robin into its groups: two wide groups and six narrow groups, twelve codewords per group. Each group is then reordered under its own 11-bit key, and all eight groups are reordered at once. The reordered codewords go back into the payload slots they were dealt from. In decode mode the block applies the inverse reordering, so a payload encoded and then decoded with the same keys returns unchanged.

A full payload moves on each beat of a valid/ready stream. The first pipeline register captures the payload, the mode and a snapshot of all eight keys. Eleven more registers each carry out one step of the reordering, one key bit per group per step. The key bank is loaded through a plain write port. That port refuses an all-zero key, because an all-zero key would leave the group in its original order.

Back-pressure rules: a beat transfers on a rising edge when valid and ready are both high. `in_ready` is high when the output register is empty or `out_ready` is high, and the whole pipeline advances together. While `out_valid` is high and `out_ready` is low, the output holds its data and no input is taken.

Top module: `payload_permuter`

## Requirements
- R1: While reset is asserted and just after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: A payload accepted into an empty pipeline with `out_ready` held high appears on `out_valid`/`out_data` right after the 11th rising edge that follows its accepting edge. Payloads leave in the order they were accepted.
- R3: Wide codeword k (bits [32k+31:32k], k = 0..23) belongs to group k mod 2, position k div 2. Narrow codeword k (bits [768+16k+15:768+16k], k = 0..71) belongs to group 2 + (k mod 6), position k div 6. After reordering, each group's position p goes back to the payload slot of that group's position p.
- R4: Encode (`in_mode` = 0) fills group positions 0..10 in turn using key bits 0..10. A 0 bit takes the lowest-numbered input position not yet used, and a 1 bit takes the highest-numbered one. Position 11 takes the one input position that is left.
- R5: Decode (`in_mode` = 1) applies the inverse of R4 in each group. Decoding an encoded payload with the same keys gives back the original payload.
- R6: Each group's key affects only that group's codewords.
- R7: A write of key `key_wr_val` into group `key_wr_grp` (0..7) affects only payloads accepted on later edges. A payload accepted on the same edge as the write uses the old key.
- R8: A key write whose value is all zeros is ignored, and the group keeps its previous key.
- R9: After reset every group key is 11'h001, and no group key is ever all zeros.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value, `out_valid` stays 1 and `in_ready` is 0. No payload is lost or duplicated.
- R11: The mode is sampled with each payload, so encode and decode payloads may follow one another back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input payload valid |
| in_ready | output | 1 | Block can take an input payload |
| in_mode | input | 1 | 0 = encode, 1 = decode |
| in_data | input | 1920 | Input payload |
| out_valid | output | 1 | Output payload valid |
| out_ready | input | 1 | Consumer takes the output payload |
| out_data | output | 1920 | Reordered payload |
| key_wr_en | input | 1 | Key write strobe |
| key_wr_grp | input | 3 | Group whose key is written |
| key_wr_val | input | 11 | Key value to write |

## Verification
A key write and the acceptance of a payload can fall on the same clock edge. The bench drives both on one edge, so the key bank changes exactly as that payload takes its key snapshot. The scoreboard predicts that payload with the old key and the next payload with the new key, so any leak of the new bits into the earlier packet shows up as a mismatch. Stalls on the output are also combined with continuous input offers to check R10.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic {
    PP_ENC = 1'b0,
    PP_DEC = 1'b1
  } pp_mode_e;

  // codeword width of group g
  function automatic int grp_width(input int g, input int nw, input int ww, input int nwd);
    return (g < nw) ? ww : nwd;
  endfunction

  // first bit of group g in the grouped layout
  function automatic int grp_base(input int g, input int nw, input int ww, input int nwd,
                                  input int cpg);
    if (g < nw) return g * cpg * ww;
    return nw * cpg * ww + (g - nw) * cpg * nwd;
  endfunction

  // first bit of the payload slot dealt to group g, position p
  function automatic int slot_base(input int g, input int p, input int nw, input int nn,
                                   input int ww, input int nwd, input int cpg);
    if (g < nw) return (p * nw + g) * ww;
    return nw * cpg * ww + (p * nn + (g - nw)) * nwd;
  endfunction

endpackage

// File: rtl/pp_interleave.sv
module pp_interleave
  import pp_pkg::*;
#(
  parameter int NW      = 2,
  parameter int NN      = 6,
  parameter int WW      = 32,
  parameter int NWD     = 16,
  parameter int CPG     = 12,
  parameter bit INVERSE = 1'b0,
  localparam int PW     = CPG * (NW * WW + NN * NWD)
) (
  input  logic [PW-1:0] src,
  output logic [PW-1:0] dst
);

  for (genvar g = 0; g < NW + NN; g++) begin : g_grp
    localparam int W  = grp_width(g, NW, WW, NWD);
    localparam int GB = grp_base(g, NW, WW, NWD, CPG);
    for (genvar p = 0; p < CPG; p++) begin : g_pos
      localparam int SB = slot_base(g, p, NW, NN, WW, NWD, CPG);
      if (INVERSE) begin : g_back
        assign dst[SB +: W] = src[GB + p * W +: W];
      end else begin : g_fwd
        assign dst[GB + p * W +: W] = src[SB +: W];
      end
    end
  end

endmodule

// File: rtl/pp_rot_step.sv
module pp_rot_step
  import pp_pkg::*;
#(
  parameter int W       = 16,
  parameter int CPG     = 12,
  parameter int ENC_IDX = 0,
  parameter int DEC_IDX = 10
) (
  input  logic             mode,
  input  logic             enc_bit,
  input  logic             dec_bit,
  input  logic [CPG*W-1:0] seg_i,
  output logic [CPG*W-1:0] seg_o
);

  // encode: rotate positions ENC_IDX..CPG-1 up by one, last wraps to ENC_IDX
  // decode: rotate positions DEC_IDX..CPG-1 down by one, undoing the encode step
  always_comb begin
    seg_o = seg_i;
    if (mode == PP_ENC && enc_bit) begin
      seg_o[ENC_IDX*W +: W] = seg_i[(CPG-1)*W +: W];
      for (int j = ENC_IDX + 1; j < CPG; j++) begin
        seg_o[j*W +: W] = seg_i[(j-1)*W +: W];
      end
    end else if (mode == PP_DEC && dec_bit) begin
      for (int j = DEC_IDX; j < CPG - 1; j++) begin
        seg_o[j*W +: W] = seg_i[(j+1)*W +: W];
      end
      seg_o[(CPG-1)*W +: W] = seg_i[DEC_IDX*W +: W];
    end
  end

endmodule

// File: rtl/pp_key_bank.sv
module pp_key_bank #(
  parameter int              NGRP    = 8,
  parameter int              KEY_W   = 11,
  parameter logic [KEY_W-1:0] RST_KEY = 1,
  localparam int             GSEL_W  = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [GSEL_W-1:0]      wr_grp,
  input  logic [KEY_W-1:0]       wr_val,
  output logic [NGRP*KEY_W-1:0]  keys
);

  logic wr_ok;
  assign wr_ok = wr_en && (|wr_val);

  for (genvar g = 0; g < NGRP; g++) begin : g_key
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        keys[g*KEY_W +: KEY_W] <= RST_KEY;
      end else if (wr_ok && wr_grp == GSEL_W'(g)) begin
        keys[g*KEY_W +: KEY_W] <= wr_val;
      end
    end
  end

endmodule

// File: rtl/payload_permuter.sv
module payload_permuter
  import pp_pkg::*;
#(
  parameter int NUM_WIDE   = 2,
  parameter int NUM_NARROW = 6,
  parameter int WIDE_W     = 32,
  parameter int NARROW_W   = 16,
  parameter int CW_PER_GRP = 12,
  parameter logic [CW_PER_GRP-2:0] RST_KEY = 1,
  localparam int NGRP   = NUM_WIDE + NUM_NARROW,
  localparam int KEY_W  = CW_PER_GRP - 1,
  localparam int NSTG   = KEY_W,
  localparam int PW     = CW_PER_GRP * (NUM_WIDE * WIDE_W + NUM_NARROW * NARROW_W),
  localparam int GSEL_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_mode,
  input  logic [PW-1:0]     in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PW-1:0]     out_data,
  input  logic              key_wr_en,
  input  logic [GSEL_W-1:0] key_wr_grp,
  input  logic [KEY_W-1:0]  key_wr_val
);

  logic [NGRP*KEY_W-1:0] keys;
  logic [PW-1:0]         grouped_in;
  logic                  advance;

  // stage 0 holds the key snapshot; stages 1..NSTG each apply one step
  logic [NSTG:0][PW-1:0]            st_d;
  logic [NSTG:0]                    st_v;
  logic [NSTG-1:0][NGRP*KEY_W-1:0]  st_k;
  logic [NSTG-1:0]                  st_m;
  logic [NSTG:1][PW-1:0]            nx;

  pp_key_bank #(
    .NGRP(NGRP), .KEY_W(KEY_W), .RST_KEY(RST_KEY)
  ) i_keys (
    .clk(clk), .rst_n(rst_n), .wr_en(key_wr_en), .wr_grp(key_wr_grp),
    .wr_val(key_wr_val), .keys(keys)
  );

  pp_interleave #(
    .NW(NUM_WIDE), .NN(NUM_NARROW), .WW(WIDE_W), .NWD(NARROW_W),
    .CPG(CW_PER_GRP), .INVERSE(1'b0)
  ) i_deal (
    .src(in_data), .dst(grouped_in)
  );

  assign advance  = !st_v[NSTG] || out_ready;
  assign in_ready = advance;

  for (genvar s = 1; s <= NSTG; s++) begin : g_stage
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int GW = grp_width(g, NUM_WIDE, WIDE_W, NARROW_W);
      localparam int GB = grp_base(g, NUM_WIDE, WIDE_W, NARROW_W, CW_PER_GRP);
      localparam int EI = s - 1;
      localparam int DI = NSTG - s;
      pp_rot_step #(
        .W(GW), .CPG(CW_PER_GRP), .ENC_IDX(EI), .DEC_IDX(DI)
      ) i_step (
        .mode   (st_m[s-1]),
        .enc_bit(st_k[s-1][g*KEY_W + EI]),
        .dec_bit(st_k[s-1][g*KEY_W + DI]),
        .seg_i  (st_d[s-1][GB +: CW_PER_GRP*GW]),
        .seg_o  (nx[s][GB +: CW_PER_GRP*GW])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v <= '0;
    end else if (advance) begin
      st_v <= {st_v[NSTG-1:0], in_valid};
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      st_d[0] <= grouped_in;
      st_k[0] <= keys;
      st_m[0] <= in_mode;
      for (int s = 1; s <= NSTG; s++) begin
        st_d[s] <= nx[s];
      end
      for (int s = 1; s < NSTG; s++) begin
        st_k[s] <= st_k[s-1];
        st_m[s] <= st_m[s-1];
      end
    end
  end

  pp_interleave #(
    .NW(NUM_WIDE), .NN(NUM_NARROW), .WW(WIDE_W), .NWD(NARROW_W),
    .CPG(CW_PER_GRP), .INVERSE(1'b1)
  ) i_gather (
    .src(st_d[NSTG]), .dst(out_data)
  );

  assign out_valid = st_v[NSTG];

endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
  parameter int NGRP  = 8,
  parameter int KEY_W = 11,
  parameter int PW    = 1920,
  parameter int NSTG  = 11
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [PW-1:0]         out_data,
  input logic                  key_wr_en,
  input logic [KEY_W-1:0]      key_wr_val,
  input logic [NGRP*KEY_W-1:0] keys
);

  int unsigned inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= 0;
    else inflight <= inflight + ((in_valid && in_ready) ? 1 : 0)
                              - ((out_valid && out_ready) ? 1 : 0);
  end

  assert_reset_R1: assert property (@(posedge clk) !rst_n |-> !out_valid);

  assert_inflight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= NSTG + 1);

  assert_no_phantom_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight > 0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_zero_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr_en && key_wr_val == '0 |=> $stable(keys));

  for (genvar g = 0; g < NGRP; g++) begin : g_nz
    assert_key_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      keys[g*KEY_W +: KEY_W] != '0);
  end

endmodule

bind payload_permuter pp_checker #(
  .NGRP(NGRP), .KEY_W(KEY_W), .PW(PW), .NSTG(NSTG)
) i_pp_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .key_wr_en(key_wr_en), .key_wr_val(key_wr_val), .keys(keys)
);

// File: tb/test_payload_permuter.sv
module test_payload_permuter;
  localparam int PW = 1920;
  localparam int NG = 8;
  localparam int KW = 11;
  localparam int CPG = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, in_valid, in_ready, in_mode, out_valid, out_ready, key_wr_en;
  logic [PW-1:0] in_data, out_data;
  logic [2:0]    key_wr_grp;
  logic [KW-1:0] key_wr_val;

  payload_permuter i_payload_permuter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .key_wr_en(key_wr_en),
    .key_wr_grp(key_wr_grp), .key_wr_val(key_wr_val)
  );

  int checks = 0;
  int errors = 0;
  bit rnd_bp = 0;
  logic [KW-1:0] mk [NG];
  logic [PW-1:0] exp_q [$];
  string         tag_q [$];
  logic [PW-1:0] last_out;

  function automatic int cw_w(input int g);
    return (g < 2) ? 32 : 16;
  endfunction

  function automatic int cw_off(input int g, input int p);
    if (g < 2) return 32 * (p * 2 + g);
    return 768 + 16 * (p * 6 + g - 2);
  endfunction

  function automatic logic [PW-1:0] model(input logic [PW-1:0] d, input bit dec);
    logic [PW-1:0] r;
    r = d;
    for (int g = 0; g < NG; g++) begin
      int src [CPG];
      int lo, hi;
      lo = 0;
      hi = CPG - 1;
      for (int i = 0; i < CPG - 1; i++) begin
        if (mk[g][i]) begin src[i] = hi; hi--; end
        else begin src[i] = lo; lo++; end
      end
      src[CPG-1] = lo;
      for (int i = 0; i < CPG; i++) begin
        for (int b = 0; b < cw_w(g); b++) begin
          if (!dec) r[cw_off(g, i) + b] = d[cw_off(g, src[i]) + b];
          else      r[cw_off(g, src[i]) + b] = d[cw_off(g, i) + b];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [PW-1:0] rand_pl();
    logic [PW-1:0] r;
    for (int i = 0; i < PW / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid) begin
      if (out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected output", out_data, '0);
        end else begin
          logic [PW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data === e, t, "payload", out_data, e);
        end
        last_out = out_data;
      end else begin
        chk(in_ready === 1'b0, "R10", "in_ready during stall", PW'(in_ready), '0);
        if (exp_q.size() != 0)
          chk(out_data === exp_q[0], "R10", "held payload", out_data, exp_q[0]);
      end
    end
  end

  always @(negedge clk) if (rnd_bp) out_ready = ($urandom % 3) != 0;

  task automatic send(input logic [PW-1:0] d, input bit mode, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_mode  = mode;
    forever begin
      #2;
      if (in_ready) begin
        exp_q.push_back(model(d, mode));
        tag_q.push_back(tag);
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic write_key(input int g, input logic [KW-1:0] k);
    @(negedge clk);
    key_wr_en  = 1'b1;
    key_wr_grp = 3'(g);
    key_wr_val = k;
    @(posedge clk);
    #1 key_wr_en = 1'b0;
    if (k != '0) mk[g] = k;
  endtask

  // payload and key write on the same edge (pipeline assumed ready)
  task automatic send_write(input logic [PW-1:0] d, input int g, input logic [KW-1:0] k);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_mode = 1'b0;
    key_wr_en = 1'b1; key_wr_grp = 3'(g); key_wr_val = k;
    #2;
    chk(in_ready === 1'b1, "R7", "ready for joint write", PW'(in_ready), PW'(1));
    exp_q.push_back(model(d, 1'b0));
    tag_q.push_back("R7");
    @(posedge clk);
    #1 in_valid = 1'b0; key_wr_en = 1'b0;
    if (k != '0) mk[g] = k;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [PW-1:0] p, o1, o2, enc;
    int n;
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 1'b0; in_data = '0;
    out_ready = 1'b1; key_wr_en = 1'b0; key_wr_grp = '0; key_wr_val = '0;
    for (int g = 0; g < NG; g++) mk[g] = 11'h001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", "out_valid in reset", PW'(out_valid), '0);
    chk(in_ready === 1'b1, "R1", "in_ready in reset", PW'(in_ready), PW'(1));
    #1 rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(out_valid === 1'b0, "R1", "out_valid after reset", PW'(out_valid), '0);

    // R9 / R3: reset keys, codeword k of each class carries its own index
    for (int k = 0; k < 24; k++) p[k*32 +: 32] = 32'hA000_0000 | 32'(k);
    for (int k = 0; k < 72; k++) p[768 + k*16 +: 16] = 16'h5000 | 16'(k);
    send(p, 1'b0, "R9");
    drain();
    // R9: position 0 of group 0 takes its position 11 (wide codeword 22)
    chk(last_out[31:0] === 1920'(32'hA000_0016), "R9", "reset key slot0",
        PW'(last_out[31:0]), PW'(32'hA000_0016));

    // R2 latency
    send(rand_pl(), 1'b0, "R2");
    n = 0;
    while (!out_valid && n < 50) begin
      @(posedge clk);
      #1 n++;
    end
    chk(n == 11, "R2", "edges to output", PW'(n), PW'(11));
    drain();

    // R3 / R4: distinct keys per group
    for (int g = 0; g < NG; g++) write_key(g, 11'(13 + 157 * g));
    send(p, 1'b0, "R3");
    for (int i = 0; i < 4; i++) send(rand_pl(), 1'b0, "R4");
    drain();

    // R11: decode, mixed back to back with encode
    for (int i = 0; i < 6; i++) send(rand_pl(), i[0], "R11");
    drain();

    // R5: round trip
    p = rand_pl();
    send(p, 1'b0, "R4");
    drain();
    enc = last_out;
    send(enc, 1'b1, "R5");
    drain();
    chk(last_out === p, "R5", "round trip", last_out, p);

    // R6: change only group 5
    p = rand_pl();
    send(p, 1'b0, "R6");
    drain();
    o1 = last_out;
    write_key(5, mk[5] ^ 11'h7FF);
    send(p, 1'b0, "R6");
    drain();
    o2 = last_out;
    for (int g = 0; g < NG; g++) begin
      bit same;
      same = 1'b1;
      for (int i = 0; i < CPG; i++)
        for (int b = 0; b < cw_w(g); b++)
          if (o1[cw_off(g, i) + b] !== o2[cw_off(g, i) + b]) same = 1'b0;
      if (g != 5) chk(same, "R6", $sformatf("group %0d untouched", g), o2, o1);
    end

    // R8: zero write ignored
    write_key(3, '0);
    send(p, 1'b0, "R8");
    drain();
    chk(last_out === o2, "R8", "zero key ignored", last_out, o2);

    // R7: write and accept on the same edge
    p = rand_pl();
    send_write(p, 2, mk[2] ^ 11'h2A5);
    send(p, 1'b0, "R7");
    drain();

    // R10: random back-pressure, streaming, key changes
    rnd_bp = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (i % 8 == 7) begin
        drain();
        write_key($urandom % NG, 11'($urandom));
      end
      send(rand_pl(), 1'($urandom), "R10");
    end
    drain();
    rnd_bp = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule